// File: doc/BRIEF.md
# Asynchronous External Memory Access Sequencer

This block drives one chip-select region of an external parallel memory bus. The attached device can be an SRAM, a PSRAM or a NOR flash. A request stream carries address, write data, byte enables and a read/write flag. Each accepted request becomes exactly one bus access.

The block steps the device pins through a fixed set of phases, and each phase length is a programmed clock-cycle count. The strobes are chip select, byte-lane selects, output enable, write enable and an address-valid strobe. The address and data buses are driven to match. Reads and writes each have their own timing word, and the byte-lane setup count is shared by both. The data bus can run 16 bits wide or be narrowed to its low byte. When the device type allows it, the address can be multiplexed onto the data lines. A wait input of selectable polarity can stretch the data phase.

Read data returns on a valid/ready response stream. The response is held stable until it is taken. While a response is pending or an access is in progress, `req_ready` stays low, so request back-pressure comes from the memory timing and from the response consumer.

Top module: `xmem_async_seq`

## Requirements
- R1: During and right after reset the bus is idle. `mem_ce_n`, `mem_oe_n`, `mem_we_n` and every `mem_bl_n` bit are 1, `mem_adv` is 0 and `mem_dq_oe` is 0. `req_ready` is 1 and `rsp_valid` is 0.
- R2: An accepted access runs its phases in a fixed order: byte-lane setup, address setup, address hold, data setup, data hold, turnaround, then idle. The cycle after acceptance is the first cycle of the first phase. Each timing word holds five 4-bit counts: address setup in bits [3:0], address hold in [7:4], data setup in [11:8], data hold in [15:12] and turnaround in [19:16]. A count of zero gives one cycle for address setup and data setup, and skips every other phase. `mem_ce_n` is low exactly during address setup, address hold, data setup and data hold. `mem_addr` carries the request address from byte-lane setup through data hold.
- R3: Each enabled byte lane's `mem_bl_n` bit is low from the first byte-lane setup cycle through the last data hold cycle. The lane's `req_be` bit must be 1 for it to be enabled. `mem_oe_n` is low only during data setup of a read, and `mem_we_n` only during data setup of a write.
- R4: A write takes its phase counts from `cfg_wr_tim` and a read from `cfg_rd_tim`. `cfg_bl_setup` serves both.
- R5: Multiplexing is in effect only when `cfg_mux_en` is 1 and `cfg_dev` is not 0. `cfg_dev` encodes 0 as SRAM, 1 as PSRAM and 2 or 3 as NOR. With multiplexing in effect, the address hold phase is present, `mem_adv` is high during address setup, and the low address bits are driven on `mem_dq_o` during address setup and address hold. Without it, the address hold phase is skipped and `mem_adv` stays 0.
- R6: A write drives its data on `mem_dq_o` from address setup through data hold. With multiplexing in effect, it drives data from data setup through data hold instead. A read drives `mem_dq_oe` only during multiplexed address phases.
- R7: When `cfg_wide` is 0 only lane 0 is used. `mem_bl_n[1]` stays 1, `mem_dq_oe[1]` stays 0, and `rsp_rdata[15:8]` is 0.
- R8: When `cfg_wait_en` is 1, the wait is asserted while `mem_wait` equals `cfg_wait_hi`. An asserted wait on the last counted data setup cycle holds the phase. The phase ends on the first cycle in which the wait is not asserted. When `cfg_wait_en` is 0, `mem_wait` has no effect.
- R9: Read data is `mem_dq_i` as sampled in the final data setup cycle. `rsp_valid` rises in the next cycle.
- R10: `rsp_valid` and `rsp_rdata` stay stable until `rsp_ready` is 1. `req_ready` stays 0 while a response is pending.
- R11: `req_ready` is 1 only when the bus is idle. It stays 0 through every phase, including turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dev | input | 2 | Device kind: 0 SRAM, 1 PSRAM, 2/3 NOR |
| cfg_mux_en | input | 1 | Request address multiplexed on the data lines |
| cfg_wide | input | 1 | 1: 16-bit data, 0: 8-bit data on lane 0 |
| cfg_wait_en | input | 1 | Honour the wait input |
| cfg_wait_hi | input | 1 | Wait asserted level (0 = active low) |
| cfg_bl_setup | input | 4 | Byte-lane setup cycles |
| cfg_rd_tim | input | 20 | Read timing word |
| cfg_wr_tim | input | 20 | Write timing word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 20 | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 20 | Device address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bl_n | output | 2 | Byte-lane selects, active low |
| mem_adv | output | 1 | Address-valid strobe, active high |
| mem_dq_o | output | 16 | Data/address lines, driven value |
| mem_dq_oe | output | 2 | Per-lane drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data lines, sampled value |
| mem_wait | input | 1 | Device wait |

## Verification
The bench builds the block with its default parameters: a 20-bit address, 16 data lines split into two byte lanes, and 4-bit phase counts. Two lanes let the narrow mode and the multiplexed address on the data lines be checked against separate lane enables. The timing words are kept short, so every phase can appear, be skipped or clamp to one cycle within a few accesses. Wait stretching is checked under both polarities and with the wait disabled.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_BLS  = 3'd1,
    PH_ASET = 3'd2,
    PH_AHLD = 3'd3,
    PH_DSET = 3'd4,
    PH_DHLD = 3'd5,
    PH_TURN = 3'd6
  } phase_e;

  // field positions inside a timing word
  localparam int F_ASET   = 0;
  localparam int F_AHLD   = 1;
  localparam int F_DSET   = 2;
  localparam int F_DHLD   = 3;
  localparam int F_TURN   = 4;
  localparam int N_FIELDS = 5;

  localparam logic [1:0] DEV_SRAM = 2'd0;
endpackage

// File: rtl/xmem_timing_sel.sv
module xmem_timing_sel import xmem_pkg::*; #(
  parameter int CNT_W = 4,
  localparam int TIM_W = N_FIELDS * CNT_W
) (
  input  logic             use_wr,
  input  logic             mux_eff,
  input  logic [TIM_W-1:0] rd_tim,
  input  logic [TIM_W-1:0] wr_tim,
  input  logic [CNT_W-1:0] bl_setup,
  output logic [CNT_W-1:0] len_bls,
  output logic [CNT_W-1:0] len_aset,
  output logic [CNT_W-1:0] len_ahld,
  output logic [CNT_W-1:0] len_dset,
  output logic [CNT_W-1:0] len_dhld,
  output logic [CNT_W-1:0] len_turn
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] fld [N_FIELDS];

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    assign fld[g] = use_wr ? wr_tim[g*CNT_W +: CNT_W] : rd_tim[g*CNT_W +: CNT_W];
  end

  assign len_bls  = bl_setup;
  assign len_aset = (fld[F_ASET] == '0) ? ONE : fld[F_ASET];
  assign len_ahld = mux_eff ? fld[F_AHLD] : '0;
  assign len_dset = (fld[F_DSET] == '0) ? ONE : fld[F_DSET];
  assign len_dhld = fld[F_DHLD];
  assign len_turn = fld[F_TURN];
endmodule

// File: rtl/xmem_seq_fsm.sv
module xmem_seq_fsm import xmem_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wait_hit,
  input  logic [CNT_W-1:0] len_bls,
  input  logic [CNT_W-1:0] len_aset,
  input  logic [CNT_W-1:0] len_ahld,
  input  logic [CNT_W-1:0] len_dset,
  input  logic [CNT_W-1:0] len_dhld,
  input  logic [CNT_W-1:0] len_turn,
  output phase_e           phase,
  output logic             dset_end
);
  logic [CNT_W-1:0] cnt;
  phase_e           nxt_ph;
  logic [CNT_W-1:0] nxt_len;
  logic             done;
  logic             leave;

  assign done = (cnt == '0);

  always_comb begin
    case (phase)
      PH_IDLE: nxt_ph = (len_bls != '0) ? PH_BLS : PH_ASET;
      PH_BLS:  nxt_ph = PH_ASET;
      PH_ASET: nxt_ph = (len_ahld != '0) ? PH_AHLD : PH_DSET;
      PH_AHLD: nxt_ph = PH_DSET;
      PH_DSET: nxt_ph = (len_dhld != '0) ? PH_DHLD :
                        (len_turn != '0) ? PH_TURN : PH_IDLE;
      PH_DHLD: nxt_ph = (len_turn != '0) ? PH_TURN : PH_IDLE;
      default: nxt_ph = PH_IDLE;
    endcase
  end

  always_comb begin
    case (nxt_ph)
      PH_BLS:  nxt_len = len_bls;
      PH_ASET: nxt_len = len_aset;
      PH_AHLD: nxt_len = len_ahld;
      PH_DSET: nxt_len = len_dset;
      PH_DHLD: nxt_len = len_dhld;
      PH_TURN: nxt_len = len_turn;
      default: nxt_len = '0;
    endcase
  end

  assign dset_end = (phase == PH_DSET) && done && !wait_hit;
  assign leave    = (phase == PH_IDLE) ? start :
                    (phase == PH_DSET) ? dset_end : done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (leave) begin
      phase <= nxt_ph;
      cnt   <= (nxt_len == '0) ? '0 : nxt_len - CNT_W'(1);
    end else if (!done) begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/xmem_pin_drv.sv
module xmem_pin_drv import xmem_pkg::*; #(
  parameter int ADDR_W = 20,
  parameter int DQ_W   = 16,
  localparam int LANES = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic              mux_eff,
  input  logic              wide,
  input  logic              dset_end,
  input  logic              rsp_ready,
  input  logic [DQ_W-1:0]   mem_dq_i,
  output logic              wr_q,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_bl_n,
  output logic              mem_adv,
  output logic [DQ_W-1:0]   mem_dq_o,
  output logic [LANES-1:0]  mem_dq_oe
);
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   wdata_q;
  logic [LANES-1:0]  be_q;
  logic [DQ_W-1:0]   cap;
  logic [LANES-1:0]  lane_on;
  logic              act_ce, act_bl, addr_ph, data_drv;

  assign act_ce   = (phase == PH_ASET) || (phase == PH_AHLD) ||
                    (phase == PH_DSET) || (phase == PH_DHLD);
  assign act_bl   = act_ce || (phase == PH_BLS);
  assign addr_ph  = mux_eff && ((phase == PH_ASET) || (phase == PH_AHLD));
  assign data_drv = wr_q && act_ce && !addr_ph;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_on[l]         = (l == 0) || wide;
    assign mem_bl_n[l]        = !(act_bl && be_q[l] && lane_on[l]);
    assign mem_dq_oe[l]       = (addr_ph || data_drv) && lane_on[l];
    assign cap[l*8 +: 8]      = lane_on[l] ? mem_dq_i[l*8 +: 8] : 8'h00;
  end

  assign mem_ce_n = !act_ce;
  assign mem_oe_n = !((phase == PH_DSET) && !wr_q);
  assign mem_we_n = !((phase == PH_DSET) && wr_q);
  assign mem_adv  = mux_eff && (phase == PH_ASET);
  assign mem_dq_o = addr_ph ? addr_q[DQ_W-1:0] : wdata_q;
  assign mem_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (dset_end && !wr_q) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= cap;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xmem_async_seq.sv
module xmem_async_seq import xmem_pkg::*; #(
  parameter int ADDR_W = 20,
  parameter int DQ_W   = 16,
  parameter int CNT_W  = 4,
  localparam int LANES = DQ_W / 8,
  localparam int TIM_W = N_FIELDS * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_dev,
  input  logic              cfg_mux_en,
  input  logic              cfg_wide,
  input  logic              cfg_wait_en,
  input  logic              cfg_wait_hi,
  input  logic [CNT_W-1:0]  cfg_bl_setup,
  input  logic [TIM_W-1:0]  cfg_rd_tim,
  input  logic [TIM_W-1:0]  cfg_wr_tim,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DQ_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_bl_n,
  output logic              mem_adv,
  output logic [DQ_W-1:0]   mem_dq_o,
  output logic [LANES-1:0]  mem_dq_oe,
  input  logic [DQ_W-1:0]   mem_dq_i,
  input  logic              mem_wait
);
  phase_e           phase;
  logic             wr_q, accept, use_wr, mux_eff, wait_hit, dset_end;
  logic [CNT_W-1:0] l_bls, l_aset, l_ahld, l_dset, l_dhld, l_turn;

  assign req_ready = (phase == PH_IDLE) && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign use_wr    = (phase == PH_IDLE) ? req_write : wr_q;
  assign mux_eff   = cfg_mux_en && (cfg_dev != DEV_SRAM);
  assign wait_hit  = cfg_wait_en && (mem_wait == cfg_wait_hi);

  xmem_timing_sel #(.CNT_W(CNT_W)) u_tim (
    .use_wr(use_wr), .mux_eff(mux_eff), .rd_tim(cfg_rd_tim), .wr_tim(cfg_wr_tim),
    .bl_setup(cfg_bl_setup), .len_bls(l_bls), .len_aset(l_aset), .len_ahld(l_ahld),
    .len_dset(l_dset), .len_dhld(l_dhld), .len_turn(l_turn)
  );

  xmem_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .wait_hit(wait_hit),
    .len_bls(l_bls), .len_aset(l_aset), .len_ahld(l_ahld), .len_dset(l_dset),
    .len_dhld(l_dhld), .len_turn(l_turn), .phase(phase), .dset_end(dset_end)
  );

  xmem_pin_drv #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase), .accept(accept),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .mux_eff(mux_eff), .wide(cfg_wide), .dset_end(dset_end), .rsp_ready(rsp_ready),
    .mem_dq_i(mem_dq_i), .wr_q(wr_q), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bl_n(mem_bl_n), .mem_adv(mem_adv), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
  );
endmodule

// File: rtl/xmem_async_seq_chk.sv
module xmem_async_seq_chk #(
  parameter int DQ_W  = 16,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_dev,
  input logic             cfg_mux_en,
  input logic             cfg_wide,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [DQ_W-1:0]  rsp_rdata,
  input logic             mem_ce_n,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic [LANES-1:0] mem_bl_n,
  input logic             mem_adv,
  input logic [LANES-1:0] mem_dq_oe
);
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_ce_n);

  assert_adv_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_adv |-> (!mem_ce_n && cfg_mux_en && (cfg_dev != 2'd0)));

  assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_dq_oe == '0));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  if (LANES > 1) begin : g_narrow
    assert_narrow_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wide |-> (mem_bl_n[1] && !mem_dq_oe[1]));
  end
endmodule

bind xmem_async_seq xmem_async_seq_chk #(.DQ_W(DQ_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dev(cfg_dev), .cfg_mux_en(cfg_mux_en),
  .cfg_wide(cfg_wide), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bl_n(mem_bl_n),
  .mem_adv(mem_adv), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_xmem_async_seq.sv
`timescale 1ns/1ps
module sim_xmem_async_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_dev = 2'd0;
  logic        cfg_mux_en = 1'b0, cfg_wide = 1'b1, cfg_wait_en = 1'b0, cfg_wait_hi = 1'b0;
  logic [3:0]  cfg_bl_setup = 4'd0;
  logic [19:0] cfg_rd_tim = '0, cfg_wr_tim = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, mem_dq_i = '0;
  logic [1:0]  req_be = '0;
  logic        mem_wait = 1'b1;
  logic        req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_adv;
  logic [15:0] rsp_rdata, mem_dq_o;
  logic [19:0] mem_addr;
  logic [1:0]  mem_bl_n, mem_dq_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  xmem_async_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dev(cfg_dev), .cfg_mux_en(cfg_mux_en),
    .cfg_wide(cfg_wide), .cfg_wait_en(cfg_wait_en), .cfg_wait_hi(cfg_wait_hi),
    .cfg_bl_setup(cfg_bl_setup), .cfg_rd_tim(cfg_rd_tim), .cfg_wr_tim(cfg_wr_tim),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bl_n(mem_bl_n), .mem_adv(mem_adv), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_wait(mem_wait)
  );

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tg, act, exp, $time);
    end
  endtask

  function automatic int fld(input logic [19:0] t, input int i);
    return int'(t[i*4 +: 4]);
  endfunction

  // phase codes: 0 idle, 1 lane setup, 2 addr setup, 3 addr hold, 4 data setup, 5 data hold, 6 turnaround
  task automatic check_pins(input int p, input bit wr, input logic [19:0] addr,
                            input logic [15:0] wd, input logic [1:0] be, input bit mx,
                            input bit rsp_e, input logic [15:0] rd_e, input string tg);
    bit ce_e  = (p >= 2 && p <= 5);
    bit bl_a  = (p >= 1 && p <= 5);
    bit aph   = mx && (p == 2 || p == 3);
    bit drv   = aph || (wr && ce_e);
    logic [1:0]  lanes = {cfg_wide, 1'b1};
    logic [1:0]  bl_e  = ~(bl_a ? (be & lanes) : 2'b00);
    logic [15:0] mask  = {{8{cfg_wide}}, 8'hFF};
    logic [15:0] dq_e  = aph ? addr[15:0] : wd;
    chk(mem_ce_n === !ce_e, tg, mem_ce_n, !ce_e);
    chk(mem_oe_n === !(p == 4 && !wr), tg, mem_oe_n, !(p == 4 && !wr));
    chk(mem_we_n === !(p == 4 && wr), tg, mem_we_n, !(p == 4 && wr));
    chk(mem_bl_n === bl_e, cfg_wide ? "R3 lanes" : "R7 lanes", mem_bl_n, bl_e);
    chk(mem_adv === (mx && p == 2), "R5 adv", mem_adv, (mx && p == 2));
    chk(mem_dq_oe === (drv ? lanes : 2'b00), cfg_wide ? "R6 drive" : "R7 drive",
        mem_dq_oe, (drv ? lanes : 2'b00));
    if (drv) chk((mem_dq_o & mask) === (dq_e & mask), "R6 dq", mem_dq_o & mask, dq_e & mask);
    if (bl_a) chk(mem_addr === addr, "R2 addr", mem_addr, addr);
    chk(req_ready === (p == 0 && !rsp_e), "R11 ready", req_ready, (p == 0 && !rsp_e));
    chk(rsp_valid === rsp_e, "R10 rsp_valid", rsp_valid, rsp_e);
    if (rsp_e) chk(rsp_rdata === rd_e, cfg_wide ? "R9 rdata" : "R7 rdata", rsp_rdata, rd_e);
  endtask

  // caller stands at a negedge with the bus idle
  task automatic run_access(input bit wr, input logic [19:0] addr, input logic [15:0] wd,
                            input logic [1:0] be, input int kwait, input logic [15:0] rdval,
                            input bit stall, input string tg);
    int ph[$];
    logic [19:0] t = wr ? cfg_wr_tim : cfg_rd_tim;
    bit mx  = cfg_mux_en && (cfg_dev != 2'd0);
    int lb  = int'(cfg_bl_setup);
    int la  = (fld(t, 0) == 0) ? 1 : fld(t, 0);
    int lah = mx ? fld(t, 1) : 0;
    int ld  = (fld(t, 2) == 0) ? 1 : fld(t, 2);
    int ldh = fld(t, 3);
    int lt  = fld(t, 4);
    int kw  = cfg_wait_en ? kwait : 0;
    int dtot = ld + kw;
    int d0  = lb + la + lah;
    int dsl = d0 + dtot - 1;
    logic [15:0] rd_e = cfg_wide ? rdval : {8'h00, rdval[7:0]};
    bit rsp_e;
    repeat (lb) ph.push_back(1);
    repeat (la) ph.push_back(2);
    repeat (lah) ph.push_back(3);
    repeat (dtot) ph.push_back(4);
    repeat (ldh) ph.push_back(5);
    repeat (lt) ph.push_back(6);
    chk(req_ready === 1'b1, "R11 idle ready", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
    rsp_ready = !stall;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < ph.size(); i++) begin
      int j = i - d0;
      bit in_d = (ph[i] == 4);
      bit w_on = in_d && (kwait > 0) && ((j < dtot - 1) || !cfg_wait_en);
      mem_wait = w_on ? cfg_wait_hi : !cfg_wait_hi;
      mem_dq_i = (in_d && j == dtot - 1) ? rdval : ~rdval;
      rsp_e = !wr && (stall ? (i > dsl) : (i == dsl + 1));
      check_pins(ph[i], wr, addr, wd, be, mx, rsp_e, rd_e, tg);
      @(posedge clk); @(negedge clk);
    end
    mem_wait = !cfg_wait_hi;
    rsp_e = !wr && (stall || (dsl == ph.size() - 1));
    check_pins(0, wr, addr, wd, be, mx, rsp_e, rd_e, tg);
    if (stall && !wr) begin
      repeat (3) begin
        @(posedge clk); @(negedge clk);
        check_pins(0, wr, addr, wd, be, mx, 1'b1, rd_e, "R10 stall");
      end
      rsp_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      check_pins(0, wr, addr, wd, be, mx, 1'b0, rd_e, "R10 release");
    end else if (rsp_e) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_pins(0, 0, '0, '0, 2'b00, 0, 0, '0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_pins(0, 0, '0, '0, 2'b00, 0, 0, '0, "R1 after reset");

    // R2: separate buses, every phase present, address hold count ignored
    cfg_bl_setup = 4'd1; cfg_rd_tim = 20'h21352; cfg_wr_tim = 20'h12431;
    run_access(0, 20'hABCDE, 16'h0, 2'b11, 0, 16'h5A3C, 0, "R2");
    // R4: write timing word, one lane enabled
    run_access(1, 20'h01234, 16'hBEEF, 2'b01, 0, 16'h0, 0, "R4");
    // R2: all counts zero
    cfg_bl_setup = 4'd0; cfg_rd_tim = '0; cfg_wr_tim = '0;
    run_access(0, 20'h00F0F, 16'h0, 2'b11, 0, 16'h1234, 0, "R2 zero");
    run_access(1, 20'h0F0F0, 16'h4321, 2'b10, 0, 16'h0, 0, "R2 zero");
    // R5: multiplexed on PSRAM, then refused on SRAM
    cfg_dev = 2'd1; cfg_mux_en = 1'b1; cfg_bl_setup = 4'd2; cfg_rd_tim = 20'h10223;
    run_access(0, 20'h3C0DE, 16'h0, 2'b11, 0, 16'hC0DE, 0, "R5");
    cfg_dev = 2'd0;
    run_access(0, 20'h3C0DE, 16'h0, 2'b11, 0, 16'h9876, 0, "R5 sram");
    // R6: multiplexed NOR write
    cfg_dev = 2'd2; cfg_wr_tim = 20'h01312;
    run_access(1, 20'h55AA5, 16'h7E81, 2'b11, 0, 16'h0, 0, "R6");
    // R7: narrow bus
    cfg_dev = 2'd0; cfg_mux_en = 1'b0; cfg_wide = 1'b0; cfg_bl_setup = 4'd1;
    cfg_rd_tim = 20'h11212; cfg_wr_tim = 20'h11212;
    run_access(0, 20'h00042, 16'h0, 2'b11, 0, 16'hA55A, 0, "R7");
    run_access(1, 20'h00043, 16'h1357, 2'b11, 0, 16'h0, 0, "R7");
    // R8: wait stretching, both polarities, then disabled
    cfg_wide = 1'b1; cfg_wait_en = 1'b1; cfg_wait_hi = 1'b0; cfg_rd_tim = 20'h01222;
    @(negedge clk); mem_wait = 1'b1;
    run_access(0, 20'h11111, 16'h0, 2'b11, 3, 16'h6161, 0, "R8 low");
    cfg_wait_hi = 1'b1; mem_wait = 1'b0;
    run_access(0, 20'h22222, 16'h0, 2'b11, 2, 16'h7272, 0, "R8 high");
    run_access(1, 20'h22223, 16'hD00D, 2'b11, 2, 16'h0, 0, "R8 write");
    cfg_wait_en = 1'b0;
    run_access(0, 20'h33333, 16'h0, 2'b11, 3, 16'h8383, 0, "R8 off");
    // R10: response back-pressure
    run_access(0, 20'h44444, 16'h0, 2'b11, 0, 16'h9494, 1, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule